// File: doc/BRIEF.md
# UART Transmitter with End-of-Transmission Event

This block serializes bytes onto a single TX line without a FIFO. Software writes a byte into one holding register; the serializer copies it at the start of a frame and sends a low start bit, eight data bits with the least significant bit first, and one or two high stop bits. Every bit lasts a programmable number of system clocks. The holding register stays occupied until the frame's first stop bit begins. At that moment it is freed and a transmit-ready event is raised, so the next byte can be queued while the stop bits are still on the line.

A second event, end-of-transmission, is raised only when the last configured stop bit has fully left the line and no further byte is waiting. Software turns off the ready interrupt and turns on the end interrupt when it writes its final byte. It can then release an external line driver at exactly the right time. The end event comes from the transmit state alone. A receive request merely competes for the shared interrupt index.

Each event has a sticky flag, an enable and a write-one-to-clear input. A fixed-priority index reports the one enabled pending source, ranking receive above ready above end.

Top module: `uart_tx_eot`

## Requirements
- R1: The line idles high. A frame is one low start bit, then eight data bits least significant first, then stop bits driven high. Each bit lasts `divisor` clocks, and a divisor of 0 behaves as 1.
- R2: With `stop_two` at 1 the frame carries two stop bits; with it at 0, one stop bit.
- R3: `rdy_flag` sets on the clock edge where the first stop bit begins. For a byte written into an idle block and accepted at edge E0, this is edge E0+1+9·D, where D is the effective divisor. The holding register becomes free at that same edge.
- R4: `eot_flag` sets on the edge where the last stop bit ends (E0+1+(9+S)·D, with S stop bits), but only if the holding register is empty then. The line stays high afterwards.
- R5: A byte accepted during the stop bits makes the line go low for the next start bit on the edge where the last stop bit ends. `eot_flag` stays clear at that edge.
- R6: A write while the holding register is occupied is ignored, and that byte never appears on the line.
- R7: A flag stays set until a one is applied to its clear input. Flags never clear on their own.
- R8: `irq_idx` is 1 for an enabled receive request, 2 for an enabled ready flag and 3 for an enabled end flag, in that priority order. It is 0 when nothing enabled is pending, and `irq` is high exactly when `irq_idx` is not 0. Observing the index does not change any flag.
- R9: The timing of `eot_flag` is the same whether or not a receive request is pending and enabled.
- R10: After reset the line is high, both flags are clear and `irq_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clocks per bit; hold stable while a frame is in progress |
| stop_two | input | 1 | 1 selects two stop bits |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| rdy_ie | input | 1 | Enable for the ready event |
| eot_ie | input | 1 | Enable for the end-of-transmission event |
| rdy_clr | input | 1 | Write-one-to-clear for the ready flag |
| eot_clr | input | 1 | Write-one-to-clear for the end flag |
| rx_pend | input | 1 | Receive request from an external receive path |
| rx_ie | input | 1 | Enable for the receive request |
| rdy_flag | output | 1 | Sticky ready flag |
| eot_flag | output | 1 | Sticky end-of-transmission flag |
| irq_idx | output | 2 | Index of the highest-priority enabled pending event |
| irq | output | 1 | Any enabled event pending |
| txd | output | 1 | Serial output line |

## Verification
A byte accepted at edge E0 in an idle block starts its frame at E0+1. The ready flag is due at E0+1+9·D and the end flag at E0+1+(9+S)·D. The bench counts falling clock edges from the write and samples each flag one edge before and on the edge it is due. A back-to-back byte queued during the stop bits must pull the line low at the edge that would otherwise have raised the end flag. A line-decoding monitor samples each bit at mid-period and compares every received byte against the queue filled by the write driver. The index is combinational and is read half a cycle after its inputs settle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_RX   = 2'd1,
    IDX_RDY  = 2'd2,
    IDX_EOT  = 2'd3
  } irq_idx_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;

  always_comb begin
    div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    tick    = run && (cnt_q == div_eff - DIV_W'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: the bit counter never runs past the bit length
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_eff));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              stop_two,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              stop_begin,
  output logic              line_done,
  output logic              busy,
  output logic              txd
);
  tx_state_e         st_q, st_d;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic              stp_q, stp_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;

  always_comb begin
    st_d       = st_q;
    bit_d      = bit_q;
    stp_d      = stp_q;
    sh_d       = sh_q;
    txd_d      = txd_q;
    stop_begin = 1'b0;
    line_done  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        txd_d = 1'b1;
        if (hold_full) begin
          st_d  = ST_START;
          sh_d  = hold_data;
          txd_d = 1'b0;
        end
      end
      ST_START: if (tick) begin
        st_d  = ST_DATA;
        bit_d = '0;
        txd_d = sh_q[0];
      end
      ST_DATA: if (tick) begin
        if (bit_q == BC_W'(DATA_W - 1)) begin
          st_d       = ST_STOP;
          stp_d      = 1'b0;
          txd_d      = 1'b1;
          stop_begin = 1'b1;
        end else begin
          bit_d = bit_q + BC_W'(1);
          sh_d  = sh_q >> 1;
          txd_d = sh_q[1];
        end
      end
      ST_STOP: if (tick) begin
        if (stop_two && !stp_q) begin
          stp_d = 1'b1;
        end else if (hold_full) begin
          st_d  = ST_START;
          sh_d  = hold_data;
          txd_d = 1'b0;
        end else begin
          st_d      = ST_IDLE;
          line_done = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      stp_q <= 1'b0;
      sh_q  <= '0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      stp_q <= stp_d;
      sh_q  <= sh_d;
      txd_q <= txd_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign txd  = txd_q;

  // R1: idle line high, start bit low
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> txd_q);
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START) |-> !txd_q);
  // R2: every stop period keeps the line high
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP) |-> txd_q);
endmodule

// File: rtl/uart_tx_events.sv
module uart_tx_events
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdy_set,
  input  logic       eot_set,
  input  logic       rdy_clr,
  input  logic       eot_clr,
  input  logic       rdy_ie,
  input  logic       eot_ie,
  input  logic       rx_pend,
  input  logic       rx_ie,
  output logic       rdy_flag,
  output logic       eot_flag,
  output logic [1:0] irq_idx,
  output logic       irq
);
  logic rdy_q, rdy_d, eot_q, eot_d;
  irq_idx_e idx;

  always_comb begin
    rdy_d = rdy_set | (rdy_q & ~rdy_clr);
    eot_d = eot_set | (eot_q & ~eot_clr);
    if (rx_pend && rx_ie)      idx = IDX_RX;
    else if (rdy_q && rdy_ie)  idx = IDX_RDY;
    else if (eot_q && eot_ie)  idx = IDX_EOT;
    else                       idx = IDX_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      eot_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      eot_q <= eot_d;
    end
  end

  assign rdy_flag = rdy_q;
  assign eot_flag = eot_q;
  assign irq_idx  = idx;
  assign irq      = (idx != IDX_NONE);

  // R7: flags persist without a clear
  p_rdy_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !rdy_clr) |=> rdy_q);
  p_eot_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_q && !eot_clr) |=> eot_q);
  // R8: a pending enabled receive request always wins
  p_rx_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && rx_ie) |-> (irq_idx == IDX_RX));
endmodule

// File: rtl/uart_tx_eot.sv
module uart_tx_eot #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              stop_two,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rdy_ie,
  input  logic              eot_ie,
  input  logic              rdy_clr,
  input  logic              eot_clr,
  input  logic              rx_pend,
  input  logic              rx_ie,
  output logic              rdy_flag,
  output logic              eot_flag,
  output logic [1:0]        irq_idx,
  output logic              irq,
  output logic              txd
);
  logic              hold_full_q, hold_full_d;
  logic [DATA_W-1:0] hold_data_q, hold_data_d;
  logic              accept, tick, busy, stop_begin, line_done;

  always_comb begin
    accept      = wr_valid && !hold_full_q;
    hold_data_d = accept ? wr_data : hold_data_q;
    if (stop_begin)  hold_full_d = 1'b0;
    else if (accept) hold_full_d = 1'b1;
    else             hold_full_d = hold_full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_data_q <= '0;
    end else begin
      hold_full_q <= hold_full_d;
      hold_data_q <= hold_data_d;
    end
  end

  uart_tx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .run(busy), .tick(tick)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stop_two(stop_two),
    .hold_full(hold_full_q), .hold_data(hold_data_q),
    .stop_begin(stop_begin), .line_done(line_done), .busy(busy), .txd(txd)
  );

  uart_tx_events i_events (
    .clk(clk), .rst_n(rst_n), .rdy_set(stop_begin), .eot_set(line_done),
    .rdy_clr(rdy_clr), .eot_clr(eot_clr), .rdy_ie(rdy_ie), .eot_ie(eot_ie),
    .rx_pend(rx_pend), .rx_ie(rx_ie), .rdy_flag(rdy_flag),
    .eot_flag(eot_flag), .irq_idx(irq_idx), .irq(irq)
  );

  // R6: an occupied holding register keeps its byte
  p_hold_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full_q && wr_valid && !stop_begin) |=> $stable(hold_data_q));
  // R3: the ready flag rises only with the line high and the holding register free
  p_rdy_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_flag) |-> (txd && !hold_full_q));
  // R4: the end flag rises only on an idle line with nothing queued
  p_eot_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eot_flag) |-> (txd && !busy && !hold_full_q));
endmodule

// File: tb/test_uart_tx_eot.sv
module test_uart_tx_eot;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd4;
  logic        stop_two = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rdy_ie = 1'b0, eot_ie = 1'b0, rdy_clr = 1'b0, eot_clr = 1'b0;
  logic        rx_pend = 1'b0, rx_ie = 1'b0;
  logic        rdy_flag, eot_flag, irq, txd;
  logic [1:0]  irq_idx;

  int n_chk = 0, n_fail = 0;
  int bit_clks = 4;
  int stop_bits = 1;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_eot i_uart_tx_eot (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .stop_two(stop_two),
    .wr_valid(wr_valid), .wr_data(wr_data), .rdy_ie(rdy_ie), .eot_ie(eot_ie),
    .rdy_clr(rdy_clr), .eot_clr(eot_clr), .rx_pend(rx_pend), .rx_ie(rx_ie),
    .rdy_flag(rdy_flag), .eot_flag(eot_flag), .irq_idx(irq_idx), .irq(irq),
    .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_div(input int d);
    divisor  = 16'(d);
    bit_clks = (d == 0) ? 1 : d;
  endtask

  task automatic clear_flags();
    rdy_clr = 1'b1; eot_clr = 1'b1;
    @(negedge clk);
    rdy_clr = 1'b0; eot_clr = 1'b0;
  endtask

  // driver: one write strobe; the byte is expected on the line when accepted
  task automatic put_byte(input logic [7:0] b, input bit expect_sent);
    wr_valid = 1'b1; wr_data = b;
    if (expect_sent) exp_q.push_back(b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // byte into an idle block, exact flag timing (R3, R4)
  task automatic send_timed(input logic [7:0] b, input string tag);
    put_byte(b, 1'b1);
    repeat (9*bit_clks) @(negedge clk);
    chk(rdy_flag == 1'b0, {tag, " R3 early"}, rdy_flag, 0);
    @(negedge clk);
    chk(rdy_flag == 1'b1, {tag, " R3 at stop start"}, rdy_flag, 1);
    chk(txd == 1'b1, {tag, " R1 stop high"}, txd, 1);
    if (stop_bits*bit_clks > 1) repeat (stop_bits*bit_clks - 1) @(negedge clk);
    chk(eot_flag == 1'b0, {tag, " R4 early / R2 stop length"}, eot_flag, 0);
    @(negedge clk);
    chk(eot_flag == 1'b1, {tag, " R4 at last stop end"}, eot_flag, 1);
    chk(txd == 1'b1, {tag, " R4 line high"}, txd, 1);
  endtask

  task automatic wait_eot();
    int guard = 0;
    while (!eot_flag && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(eot_flag == 1'b1, "R4 eventually set", eot_flag, 1);
  endtask

  // monitor: decode the line and compare against the scoreboard queue (R1, R2)
  initial begin
    logic [7:0] got;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (bit_clks/2) @(negedge clk);
        chk(txd == 1'b0, "R1 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          got[i] = txd;
        end
        for (int s = 0; s < stop_bits; s++) begin
          repeat (bit_clks) @(negedge clk);
          chk(txd == 1'b1, "R2 stop bit high", txd, 1);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected byte", got, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R1 byte on line", got, e);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(txd == 1'b1, "R10 txd high", txd, 1);
    chk(rdy_flag == 1'b0 && eot_flag == 1'b0, "R10 flags clear", {rdy_flag, eot_flag}, 0);
    chk(irq_idx == 2'd0 && irq == 1'b0, "R10 index zero", irq_idx, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single byte, D=4, one stop bit
    set_div(4); stop_two = 1'b0; stop_bits = 1;
    rdy_ie = 1'b1;
    send_timed(8'hA5, "d4s1");
    // R8: index priorities and no clearing by observation
    chk(irq_idx == 2'd2 && irq, "R8 ready index", irq_idx, 2);
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;
    chk(irq_idx == 2'd0 && !irq, "R8 end flag not enabled", irq_idx, 0);
    eot_ie = 1'b1; #1;
    chk(irq_idx == 2'd3, "R8 end index", irq_idx, 3);
    rx_pend = 1'b1; rx_ie = 1'b1; #1;
    chk(irq_idx == 2'd1, "R8 receive first", irq_idx, 1);
    rx_pend = 1'b0; rx_ie = 1'b0;
    // R7: flag remains without a clear
    repeat (50) @(negedge clk);
    chk(eot_flag == 1'b1, "R7 sticky end flag", eot_flag, 1);
    chk(irq_idx == 2'd3, "R8 index read has no side effect", irq_idx, 3);
    clear_flags();
    chk(eot_flag == 1'b0 && rdy_flag == 1'b0, "R7 cleared by W1C", eot_flag, 0);

    // R2: two stop bits, D=3
    set_div(3); stop_two = 1'b1; stop_bits = 2;
    send_timed(8'h5A, "d3s2");
    clear_flags();

    // R9: end timing with a receive request pending and enabled
    rx_pend = 1'b1; rx_ie = 1'b1;
    send_timed(8'hC3, "R9 rx pending");
    chk(irq_idx == 2'd1, "R9/R8 receive still ranks first", irq_idx, 1);
    rx_pend = 1'b0; rx_ie = 1'b0;
    clear_flags();

    // R6: write while occupied is ignored
    put_byte(8'h3C, 1'b1);
    put_byte(8'hFF, 1'b0);
    wait_eot();
    chk(exp_q.size() == 0, "R6 only first byte sent", exp_q.size(), 0);
    clear_flags();

    // R5: byte queued during stop bits goes straight to a start bit
    put_byte(8'h81, 1'b1);
    while (!rdy_flag) @(negedge clk);
    put_byte(8'h7E, 1'b1);
    repeat (stop_bits*bit_clks - 1) @(negedge clk);
    chk(eot_flag == 1'b0, "R5 no end flag between frames", eot_flag, 0);
    chk(txd == 1'b0, "R5 next start bit", txd, 0);
    wait_eot();
    clear_flags();

    // R1: divisor 1 and divisor 0 (treated as 1)
    stop_two = 1'b0; stop_bits = 1;
    set_div(1);
    send_timed(8'h96, "d1");
    clear_flags();
    set_div(0);
    send_timed(8'h0F, "d0");
    clear_flags();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule